// File: doc/BRIEF.md
# Compare Match Flag Unit

This block watches the running value of an 8-bit timer and raises a sticky flag when that value equals a compare value held in a register. The CPU writes the compare register through its own register port and can read it back. The equality test runs on every clock cycle. The flag is only updated on a timer tick, which is a one-cycle enable that moves the timer forward.

The flag is set when the count first becomes equal to the compare value. If the count stays equal across several ticks, the flag is not set again until the count has left the compare value and come back. The interrupt request is the flag gated by two enables: a local one for this flag and a global one.

The flag can be cleared in two ways. An acknowledge pulse clears it when the interrupt is serviced. Software can also clear it by writing a one to the flag bit. If a set and a clear happen in the same cycle, the set wins.

Top module: `cmp_match_flag`

## Requirements
- R1: `match` is high in exactly those cycles in which `count` equals the stored compare value. A write to the compare register changes `match` from the following cycle onwards.
- R2: At a clock edge with `tick` high and `match` high, where `match` was low at the previous tick, `flag` becomes 1 after that edge.
- R3: At an edge where `tick` is low, a match does not set the flag.
- R4: `irq` is 1 exactly when `flag`, `cmp_ie` and `glob_ie` are all 1.
- R5: An `irq_ack` pulse clears the flag at the next edge.
- R6: A cycle with `flag_wr` high and `flag_wdata` = 1 clears the flag. A cycle with `flag_wr` high and `flag_wdata` = 0 leaves the flag unchanged.
- R7: If a set condition (R2) and a clear request (R5 or R6) fall at the same edge, the flag ends up 1.
- R8: While `count` stays equal to the compare value across consecutive ticks, the flag is set only once. It can be set again only after a tick at which `count` differed from the compare value.
- R9: A cycle with `cmp_wr` high loads `cmp_wdata` into the compare register. `cmp_rdata` shows the new value after that edge.
- R10: After reset the compare register is 0, `flag` is 0 and `irq` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Timer tick enable, one cycle wide |
| count | input | 8 | Current timer value |
| cmp_wr | input | 1 | Write strobe for the compare register |
| cmp_wdata | input | 8 | Data written to the compare register |
| cmp_rdata | output | 8 | Readback of the compare register |
| flag_wr | input | 1 | Write strobe for the flag bit |
| flag_wdata | input | 1 | Flag write data; 1 clears, 0 does nothing |
| cmp_ie | input | 1 | Local interrupt enable for this flag |
| glob_ie | input | 1 | Global interrupt enable |
| irq_ack | input | 1 | Interrupt serviced pulse; clears the flag |
| match | output | 1 | Count equals compare value |
| flag | output | 1 | Sticky compare flag |
| irq | output | 1 | Interrupt request |

## Verification
Setting the flag and clearing it can fall on the same edge. This is the case the bench targets. To provoke it, the count is first moved off the compare value at a tick, then put back on it at a tick while `irq_ack` is pulsed. The same is done again with a write of one to the flag bit. A separate scoreboard model of the flag predicts a 1 for both edges, and the observed flag after each edge is compared against that prediction. Clears that fall on edges with no set condition are checked as well, so the priority is judged in both directions.

// File: rtl/cmp_match_flag.sv
module cmp_match_flag #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic [W-1:0] count,
  input  logic         cmp_wr,
  input  logic [W-1:0] cmp_wdata,
  output logic [W-1:0] cmp_rdata,
  input  logic         flag_wr,
  input  logic         flag_wdata,
  input  logic         cmp_ie,
  input  logic         glob_ie,
  input  logic         irq_ack,
  output logic         match,
  output logic         flag,
  output logic         irq
);

  logic [W-1:0] cmp_q;
  logic         hist_q;
  logic         set_c;
  logic         clr_c;

  assign match     = (count == cmp_q);
  assign cmp_rdata = cmp_q;
  assign set_c     = tick && match && !hist_q;
  assign clr_c     = irq_ack || (flag_wr && flag_wdata);
  assign irq       = flag && cmp_ie && glob_ie;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cmp_q <= '0;
    else if (cmp_wr) cmp_q <= cmp_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    hist_q <= 1'b0;
    else if (tick) hist_q <= match;
  end

  // set has priority over any clear
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     flag <= 1'b0;
    else if (set_c) flag <= 1'b1;
    else if (clr_c) flag <= 1'b0;
  end

  assert_cmp_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_wr |=> cmp_rdata == $past(cmp_wdata));

  assert_set_on_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && match && !hist_q) |=> flag);

  assert_no_tick_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !irq_ack && !flag_wr) |=> $stable(flag));

  assert_ack_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ack && !(tick && match && !hist_q)) |=> !flag);

  assert_write_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_wr && !flag_wdata && !irq_ack && !tick) |=> $stable(flag));

  assert_set_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && match && !hist_q && (irq_ack || flag_wr)) |=> flag);

  assert_irq_gate_R4: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (flag && cmp_ie && glob_ie));

endmodule

// File: tb/test_cmp_match_flag.sv
module test_cmp_match_flag;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0, cmp_wr = 1'b0, flag_wr = 1'b0, flag_wdata = 1'b0;
  logic       cmp_ie = 1'b0, glob_ie = 1'b0, irq_ack = 1'b0;
  logic [7:0] count = 8'd0, cmp_wdata = 8'd0;
  logic [7:0] cmp_rdata;
  logic       match, flag, irq;

  cmp_match_flag #(.W(8)) i_cmp_match_flag (
    .clk(clk), .rst_n(rst_n), .tick(tick), .count(count),
    .cmp_wr(cmp_wr), .cmp_wdata(cmp_wdata), .cmp_rdata(cmp_rdata),
    .flag_wr(flag_wr), .flag_wdata(flag_wdata), .cmp_ie(cmp_ie),
    .glob_ie(glob_ie), .irq_ack(irq_ack), .match(match), .flag(flag), .irq(irq)
  );

  always #5 clk = ~clk;

  typedef struct {
    logic       f;
    logic       i;
    logic       m;
    logic [7:0] c;
    string      tag;
  } item_t;

  item_t q[$];
  int errors = 0;
  int checks = 0;

  logic       m_flag = 1'b0;
  logic       m_hist = 1'b0;
  logic [7:0] m_cmp  = 8'd0;

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step(input logic tk, input logic [7:0] cnt, input logic cw,
                      input logic [7:0] cwd, input logic fw, input logic fwd,
                      input logic lie, input logic gie, input logic ack,
                      input string tag);
    item_t it;
    logic  mnow, setc, clrc;
    @(negedge clk);
    tick = tk; count = cnt; cmp_wr = cw; cmp_wdata = cwd;
    flag_wr = fw; flag_wdata = fwd; cmp_ie = lie; glob_ie = gie; irq_ack = ack;
    mnow = (cnt == m_cmp);
    setc = tk && mnow && !m_hist;
    clrc = ack || (fw && fwd);
    if (setc) m_flag = 1'b1;
    else if (clrc) m_flag = 1'b0;
    if (tk) m_hist = mnow;
    if (cw) m_cmp = cwd;
    it.f = m_flag;
    it.i = m_flag && lie && gie;
    it.m = (cnt == m_cmp);
    it.c = m_cmp;
    it.tag = tag;
    q.push_back(it);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (q.size() > 0) begin
        item_t it;
        it = q.pop_front();
        chk({it.tag, " flag"},  {7'd0, flag},  {7'd0, it.f});
        chk({it.tag, " irq"},   {7'd0, irq},   {7'd0, it.i});
        chk({it.tag, " match"}, {7'd0, match}, {7'd0, it.m});
        chk({it.tag, " cmp"},   cmp_rdata,     it.c);
      end
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R10 reset cmp", cmp_rdata, 8'd0);
    chk("R10 reset flag", {7'd0, flag}, 8'd0);
    chk("R10 reset irq", {7'd0, irq}, 8'd0);
    @(negedge clk); rst_n = 1'b1;
    //     tk cnt  cw cwd  fw fwd lie gie ack
    step(0, 8'd0, 1, 8'd5, 0, 0, 0, 0, 0, "R9 load cmp");
    step(0, 8'd5, 0, 8'd0, 0, 0, 0, 0, 0, "R3 match no tick");
    step(0, 8'd5, 0, 8'd0, 0, 0, 1, 1, 0, "R3 hold no tick");
    step(1, 8'd5, 0, 8'd0, 0, 0, 0, 0, 0, "R2 set on tick");
    step(1, 8'd5, 0, 8'd0, 0, 0, 1, 0, 0, "R4 global off");
    step(0, 8'd5, 0, 8'd0, 0, 0, 0, 1, 0, "R4 local off");
    step(0, 8'd5, 0, 8'd0, 0, 0, 1, 1, 0, "R4 both on");
    step(1, 8'd5, 0, 8'd0, 0, 0, 1, 1, 1, "R5 ack clears");
    step(1, 8'd5, 0, 8'd0, 0, 0, 1, 1, 0, "R8 no reset while equal");
    step(1, 8'd6, 0, 8'd0, 0, 0, 1, 1, 0, "R8 leave equality");
    step(1, 8'd5, 0, 8'd0, 0, 0, 1, 1, 0, "R8 re-entry sets");
    step(0, 8'd5, 0, 8'd0, 1, 0, 1, 1, 0, "R6 write zero ignored");
    step(0, 8'd5, 0, 8'd0, 1, 1, 1, 1, 0, "R6 write one clears");
    step(1, 8'd7, 0, 8'd0, 0, 0, 0, 0, 0, "R8 off value");
    step(1, 8'd5, 0, 8'd0, 0, 0, 0, 0, 1, "R7 set beats ack");
    step(1, 8'd4, 0, 8'd0, 0, 0, 0, 0, 1, "R5 ack off value");
    step(1, 8'd5, 0, 8'd0, 1, 1, 0, 0, 0, "R7 set beats write");
    step(0, 8'd5, 1, 8'hFF, 0, 0, 0, 0, 0, "R1 write changes match");
    step(0, 8'hFF, 0, 8'd0, 0, 0, 0, 0, 0, "R1 match max value");
    step(1, 8'hFE, 0, 8'd0, 0, 0, 0, 0, 1, "R1 no match");
    step(0, 8'hFF, 1, 8'd0, 0, 0, 0, 0, 0, "R9 load zero");
    step(1, 8'd0, 0, 8'd0, 0, 0, 1, 1, 0, "R2 set at zero");
    step(0, 8'd0, 0, 8'd0, 0, 0, 1, 1, 0, "R4 final");
    @(negedge clk);
    @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule